// File: doc/BRIEF.md
# I2C Byte Shifter with Arbitration Detection

This block is the byte-wide serial data path of an I2C controller that can act as master or slave. One register shifts transmit data out, most significant bit first, and shifts the sampled bus value in at the same time. At the end of every byte the register therefore holds exactly what was on the wire. This holds even when another master has taken the bus partway through the byte.

A separate clock generator supplies single-cycle strobes for the SCL rising and falling edges. That generator also owns START/STOP and the SCL divider. The shifter samples SDA on each rising strobe and presents its next bit after each falling strobe.

SDA is open-drain. `sda_oe` high pulls the line low. `sda_oe` low releases the line, which the pull-up then holds at 1.

The block watches for lost arbitration in two places:
- **Master transmit:** arbitration is lost when a released 1 is read back as 0. The block drops to slave receiver at once, releases SDA, and keeps asking for clock pulses until the current byte's data bits are done.
- **Master receive:** arbitration is lost only when the block is sending a NACK in the acknowledge slot and finds the line low. In that case it stops asking for clock pulses immediately.

Top module: `i2c_byte_shifter`

## Requirements
- R1: After reset the block behaves as follows:
  - `sda_oe` is 0 and `arb_lost` is 0.
  - `scl_run` is 0 and `rx_byte` is 0.
  - `mode_out` is slave receiver. The mode encoding is 2'b00 slave receiver, 2'b01 master transmit, 2'b10 master receive; 2'b11 is taken as slave receiver.
- R2: `load_en` writes `load_data` and `mode_in`, and restarts the byte at data slot 0.
  - In master transmit, slot k (k = 0..7) carries `load_data[7-k]`.
  - Each bit appears one cycle after `load_en`, or one cycle after the falling strobe that opens its slot.
  - `sda_oe` is the inverse of the bit being sent.
- R3: On the rising strobe of slot 7, `rx_byte` takes the eight sampled bits, the slot-0 bit in bit 7. `rx_valid` pulses high for the one cycle that follows.
- R4: `rx_byte` holds the bus value and not the transmitted value. It therefore equals the wired-AND of the transmitted bits and any other driver, including bits sampled after arbitration was lost.
- R5: Master transmit, data slot, the block is sending 1 and samples 0 on a rising strobe. In the following cycle the block shows:
  - `arb_lost` = 1
  - `mode_out` = slave receiver
  - `to_slave` = 1 for that one cycle
- R6: From the cycle after a master-transmit loss, SDA is released for every remaining data slot of the byte.
- R7: After a master-transmit loss, `scl_run` stays 1. It falls to 0 one cycle after the falling strobe that ends data slot 7, including when the loss itself happened in slot 7.
- R8: In master receive and in slave receiver mode, data slots are released. The acknowledge slot (slot 8) carries `ack_drive`, where 0 means ACK and 1 means NACK. In master transmit the acknowledge slot is released.
- R9: Master receive, acknowledge slot, the block is sending NACK and samples 0. In the following cycle `arb_lost` = 1, `mode_out` = slave receiver and `scl_run` = 0.
- R10: None of the following sets `arb_lost`:
  - a sampled 0 while the block itself sends 0
  - a 0 in the master-transmit acknowledge slot
  - a 0 in a master-receive data slot
  - a 0 while the block sends ACK
  - any 0 in slave receiver mode
- R11: `arb_lost` stays 1 until `arb_clr`. If a loss and `arb_clr` occur in the same cycle, the flag ends up set.
- R12: On the rising strobe of the acknowledge slot, `ack_rx` takes the sampled SDA value. `scl_run` is 1 whenever the mode is a master mode and no master-receive loss has occurred.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_rise | input | 1 | Single-cycle strobe at an SCL rising edge |
| scl_fall | input | 1 | Single-cycle strobe at an SCL falling edge |
| sda_in | input | 1 | Synchronized SDA line level |
| mode_in | input | 2 | Mode captured on load_en |
| load_en | input | 1 | Load a byte and mode, restart at slot 0 |
| load_data | input | 8 | Byte to transmit |
| ack_drive | input | 1 | Acknowledge value to send as receiver (1 = NACK) |
| arb_clr | input | 1 | Clear the arbitration-lost flag |
| sda_oe | output | 1 | Pull SDA low when 1 |
| rx_byte | output | 8 | Last byte seen on the bus |
| rx_valid | output | 1 | One-cycle pulse when rx_byte is updated |
| ack_rx | output | 1 | SDA level sampled in the acknowledge slot |
| arb_lost | output | 1 | Sticky arbitration-lost flag |
| to_slave | output | 1 | One-cycle pulse on the switch to slave receiver |
| mode_out | output | 2 | Current operating mode |
| scl_run | output | 1 | Request to the clock generator to keep pulsing SCL |

## Verification
The hardest case to reach is a master-transmit loss in the very last data slot. There, the extra clock pulses granted by the loss end on the same falling strobe that closes the slot. A close second is a loss that lands in the same cycle as `arb_clr`.

The bench models a second bus device as a per-slot bit pattern that is wired-AND with the block's own drive. It then places a single 0 in chosen slots: slot 7 in master transmit, and the acknowledge slot in master receive with NACK. A per-byte clear slot lines `arb_clr` up with the loss strobe. Random bytes, modes and interfering patterns fill in the remaining combinations.

// File: rtl/ibs_pkg.sv
`timescale 1ns/1ps
package ibs_pkg;

  typedef enum logic [1:0] {
    MODE_SLV = 2'b00,
    MODE_MTX = 2'b01,
    MODE_MRX = 2'b10
  } bus_mode_e;

  function automatic bus_mode_e norm_mode(input logic [1:0] raw);
    case (raw)
      2'b01:   return MODE_MTX;
      2'b10:   return MODE_MRX;
      default: return MODE_SLV;
    endcase
  endfunction

  function automatic logic is_master(input bus_mode_e m);
    return (m == MODE_MTX) || (m == MODE_MRX);
  endfunction

endpackage

// File: rtl/ibs_bit_counter.sv
`timescale 1ns/1ps
module ibs_bit_counter #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             scl_fall,
  output logic [CNT_W-1:0] cnt,
  output logic             in_data,
  output logic             in_ack,
  output logic             last_data
);

  localparam logic [CNT_W-1:0] ACK_IDX  = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= '0;
    end else if (scl_fall) begin
      if (cnt == ACK_IDX) cnt <= '0;
      else                cnt <= cnt + 1'b1;
    end
  end

  assign in_ack    = (cnt == ACK_IDX);
  assign in_data   = (cnt < ACK_IDX);
  assign last_data = (cnt == LAST_IDX);

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= ACK_IDX);  // R2

  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (in_ack && scl_fall && !load) |=> (cnt == '0));  // R2

endmodule

// File: rtl/ibs_shift_reg.sv
`timescale 1ns/1ps
module ibs_shift_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              scl_rise,
  input  logic              sda_in,
  input  logic              in_data,
  input  logic              in_ack,
  input  logic              last_data,
  output logic [DATA_W-1:0] shreg,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_valid,
  output logic              ack_rx
);

  logic [DATA_W-1:0] shifted;
  assign shifted = {shreg[DATA_W-2:0], sda_in};

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg    <= '0;
      rx_byte  <= '0;
      rx_valid <= 1'b0;
      ack_rx   <= 1'b1;
    end else begin
      rx_valid <= 1'b0;
      if (load) begin
        shreg <= load_data;
      end else if (scl_rise && in_data) begin
        shreg <= shifted;
        if (last_data) begin
          rx_byte  <= shifted;
          rx_valid <= 1'b1;
        end
      end else if (scl_rise && in_ack) begin
        ack_rx <= sda_in;
      end
    end
  end

  AST_RX_PULSE_ONE: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);  // R3

  AST_RX_LSB_IS_BUS: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> (rx_byte[0] == $past(sda_in)));  // R4

endmodule

// File: rtl/ibs_arbiter.sv
`timescale 1ns/1ps
module ibs_arbiter
  import ibs_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      load,
  input  logic [1:0] mode_in,
  input  logic      scl_rise,
  input  logic      scl_fall,
  input  logic      sda_in,
  input  logic      tx_bit,
  input  logic      in_data,
  input  logic      in_ack,
  input  logic      last_data,
  input  logic      arb_clr,
  output bus_mode_e mode_q,
  output logic      arb_lost,
  output logic      lose_now,
  output logic      to_slave,
  output logic      scl_run
);

  logic lose_mtx, lose_mrx, drain;

  assign lose_mtx = scl_rise && (mode_q == MODE_MTX) && in_data && tx_bit && !sda_in;
  assign lose_mrx = scl_rise && (mode_q == MODE_MRX) && in_ack  && tx_bit && !sda_in;
  assign lose_now = lose_mtx || lose_mrx;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_SLV;
      drain   <= 1'b0;
      scl_run <= 1'b0;
    end else if (load) begin
      mode_q  <= norm_mode(mode_in);
      drain   <= 1'b0;
      scl_run <= is_master(norm_mode(mode_in));
    end else if (lose_mtx) begin
      mode_q  <= MODE_SLV;
      drain   <= 1'b1;
      scl_run <= 1'b1;
    end else if (lose_mrx) begin
      mode_q  <= MODE_SLV;
      drain   <= 1'b0;
      scl_run <= 1'b0;
    end else if (scl_fall && last_data && drain) begin
      drain   <= 1'b0;
      scl_run <= is_master(mode_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      arb_lost <= 1'b0;
      to_slave <= 1'b0;
    end else begin
      to_slave <= lose_now;
      if (lose_now)     arb_lost <= 1'b1;
      else if (arb_clr) arb_lost <= 1'b0;
    end
  end

  AST_LOSS_TO_SLAVE: assert property (@(posedge clk) disable iff (rst)
    (lose_now && !load) |=> (mode_q == MODE_SLV && arb_lost && to_slave));  // R5

  AST_MRX_LOSS_HALTS: assert property (@(posedge clk) disable iff (rst)
    (lose_mrx && !load) |=> !scl_run);  // R9

  AST_DRAIN_KEEPS_CLOCK: assert property (@(posedge clk) disable iff (rst)
    drain |-> scl_run);  // R7

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (arb_lost && !arb_clr) |=> arb_lost);  // R11

  AST_SLAVE_NEVER_LOSES: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_SLV && !arb_lost && !lose_now && !arb_clr) |=> !arb_lost);  // R10

endmodule

// File: rtl/ibs_drive.sv
`timescale 1ns/1ps
module ibs_drive
  import ibs_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      load,
  input  logic [1:0] mode_in,
  input  logic      load_msb,
  input  logic      scl_fall,
  input  bus_mode_e mode_q,
  input  logic      lose_now,
  input  logic      last_data,
  input  logic      shreg_msb,
  input  logic      ack_drive,
  output logic      tx_bit,
  output logic      sda_oe
);

  logic tx_next;

  always_comb begin
    tx_next = tx_bit;
    if (load) begin
      tx_next = (norm_mode(mode_in) == MODE_MTX) ? load_msb : 1'b1;
    end else if (lose_now) begin
      tx_next = 1'b1;
    end else if (scl_fall) begin
      if (last_data) tx_next = (mode_q == MODE_MTX) ? 1'b1 : ack_drive;
      else           tx_next = (mode_q == MODE_MTX) ? shreg_msb : 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_bit <= 1'b1;
      sda_oe <= 1'b0;
    end else begin
      tx_bit <= tx_next;
      sda_oe <= !tx_next;
    end
  end

  AST_RELEASE_ON_LOSS: assert property (@(posedge clk) disable iff (rst)
    (lose_now && !load) |=> !sda_oe);  // R6

  AST_OE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!load && !lose_now && !scl_fall) |=> $stable(sda_oe));  // R2

endmodule

// File: rtl/i2c_byte_shifter.sv
`timescale 1ns/1ps
module i2c_byte_shifter
  import ibs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_in,
  input  logic [1:0]        mode_in,
  input  logic              load_en,
  input  logic [DATA_W-1:0] load_data,
  input  logic              ack_drive,
  input  logic              arb_clr,
  output logic              sda_oe,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_valid,
  output logic              ack_rx,
  output logic              arb_lost,
  output logic              to_slave,
  output logic [1:0]        mode_out,
  output logic              scl_run
);

  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [CNT_W-1:0]  cnt;
  logic              in_data, in_ack, last_data;
  logic [DATA_W-1:0] shreg;
  logic              tx_bit, lose_now;
  bus_mode_e         mode_q;

  ibs_bit_counter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load(load_en), .scl_fall(scl_fall),
    .cnt(cnt), .in_data(in_data), .in_ack(in_ack), .last_data(last_data)
  );

  ibs_shift_reg #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .load(load_en), .load_data(load_data),
    .scl_rise(scl_rise), .sda_in(sda_in), .in_data(in_data),
    .in_ack(in_ack), .last_data(last_data), .shreg(shreg),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .ack_rx(ack_rx)
  );

  ibs_arbiter u_arb (
    .clk(clk), .rst(rst), .load(load_en), .mode_in(mode_in),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_in(sda_in),
    .tx_bit(tx_bit), .in_data(in_data), .in_ack(in_ack),
    .last_data(last_data), .arb_clr(arb_clr), .mode_q(mode_q),
    .arb_lost(arb_lost), .lose_now(lose_now), .to_slave(to_slave),
    .scl_run(scl_run)
  );

  ibs_drive u_drv (
    .clk(clk), .rst(rst), .load(load_en), .mode_in(mode_in),
    .load_msb(load_data[DATA_W-1]), .scl_fall(scl_fall), .mode_q(mode_q),
    .lose_now(lose_now), .last_data(last_data), .shreg_msb(shreg[DATA_W-1]),
    .ack_drive(ack_drive), .tx_bit(tx_bit), .sda_oe(sda_oe)
  );

  assign mode_out = mode_q;

  AST_SLAVE_DATA_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (mode_q != MODE_MTX && in_data && !$past(load_en)) |-> !sda_oe);  // R8

endmodule

// File: tb/sim_i2c_byte_shifter.sv
`timescale 1ns/1ps
module sim_i2c_byte_shifter;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_rise = 1'b0, scl_fall = 1'b0, sda_in;
  logic [1:0] mode_in = 2'b00;
  logic load_en = 1'b0, ack_drive = 1'b1, arb_clr = 1'b0;
  logic [7:0] load_data = 8'h00;
  logic sda_oe, rx_valid, ack_rx, arb_lost, to_slave, scl_run;
  logic [7:0] rx_byte;
  logic [1:0] mode_out;
  logic other_bit = 1'b1;

  int tests = 0;
  int fails = 0;
  logic exp_arb = 1'b0;

  always #2.5 clk = ~clk;

  assign sda_in = other_bit & ~sda_oe;

  i2c_byte_shifter u0 (
    .clk(clk), .rst(rst), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_in(sda_in), .mode_in(mode_in), .load_en(load_en),
    .load_data(load_data), .ack_drive(ack_drive), .arb_clr(arb_clr),
    .sda_oe(sda_oe), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .ack_rx(ack_rx), .arb_lost(arb_lost), .to_slave(to_slave),
    .mode_out(mode_out), .scl_run(scl_run)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic slot_drive(input logic [1:0] m, input int slot,
                                      input logic [7:0] d, input logic ackd);
    if (slot < 8) return (m == 2'b01) ? d[7-slot] : 1'b1;
    return (m == 2'b01) ? 1'b1 : ackd;
  endfunction

  task automatic run_byte(input logic [1:0] m, input logic [7:0] d,
                          input logic [8:0] oth, input logic ackd, input int clr_slot);
    logic [1:0] em;
    logic drain;
    logic [7:0] exp_rx;
    em = m;
    drain = 1'b0;
    exp_rx = 8'h00;
    @(negedge clk);
    load_en = 1'b1; mode_in = m; load_data = d; ack_drive = ackd;
    @(negedge clk);
    load_en = 1'b0;
    chk("R2", "mode after load", {30'd0, mode_out}, {30'd0, m});
    chk("R12", "scl_run after load", {31'd0, scl_run}, {31'd0, m != 2'b00});
    for (int i = 0; i < 9; i++) begin
      logic ed, bus, loss;
      ed = slot_drive(em, i, d, ackd);
      chk((em == 2'b01) ? "R2" : "R8", "sda_oe in slot", {31'd0, sda_oe}, {31'd0, ~ed});
      other_bit = oth[i];
      bus = ed & oth[i];
      loss = ((em == 2'b01) && i < 8 && ed && !bus) ||
             ((em == 2'b10) && i == 8 && ed && !bus);
      if (i == clr_slot) arb_clr = 1'b1;
      scl_rise = 1'b1;
      @(negedge clk);
      scl_rise = 1'b0;
      if (loss) begin
        drain = (em == 2'b01);
        em = 2'b00;
        exp_arb = 1'b1;
      end else if (i == clr_slot) begin
        exp_arb = 1'b0;
      end
      arb_clr = 1'b0;
      if (i < 8) exp_rx[7-i] = bus;
      chk(loss ? "R11" : "R10", "arb_lost after rise", {31'd0, arb_lost}, {31'd0, exp_arb});
      chk("R5", "to_slave pulse", {31'd0, to_slave}, {31'd0, loss});
      chk("R5", "mode after rise", {30'd0, mode_out}, {30'd0, em});
      if (loss) chk("R6", "released after loss", {31'd0, sda_oe}, 32'd0);
      if (i == 7) begin
        chk("R3", "rx_valid", {31'd0, rx_valid}, 32'd1);
        chk("R4", "rx_byte bus value", {24'd0, rx_byte}, {24'd0, exp_rx});
      end
      if (i == 8) chk("R12", "ack_rx", {31'd0, ack_rx}, {31'd0, bus});
      chk((loss && i == 8) ? "R9" : "R7", "scl_run after rise",
          {31'd0, scl_run}, {31'd0, (em != 2'b00) || drain});
      @(negedge clk);
      scl_fall = 1'b1;
      @(negedge clk);
      scl_fall = 1'b0;
      if (i == 7) drain = 1'b0;
      chk("R7", "scl_run after fall", {31'd0, scl_run}, {31'd0, (em != 2'b00) || drain});
    end
    other_bit = 1'b1;
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL all watchdog actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "reset sda_oe", {31'd0, sda_oe}, 32'd0);
    chk("R1", "reset arb_lost", {31'd0, arb_lost}, 32'd0);
    chk("R1", "reset scl_run", {31'd0, scl_run}, 32'd0);
    chk("R1", "reset rx_byte", {24'd0, rx_byte}, 32'd0);
    chk("R1", "reset mode", {30'd0, mode_out}, 32'd0);
    // R2 R4: clean master transmit
    run_byte(2'b01, 8'hA5, 9'h1FF, 1'b1, -1);
    // R10: master transmit acknowledged by a receiver
    run_byte(2'b01, 8'h3C, 9'h0FF, 1'b1, -1);
    // R5 R6 R7: loss at slot 3
    run_byte(2'b01, 8'hFF, 9'h1FF & ~9'h008, 1'b1, -1);
    // R7: loss in the last data slot
    exp_arb = 1'b0;
    arb_clr = 1'b1; @(negedge clk); arb_clr = 1'b0;
    run_byte(2'b01, 8'h01, 9'h1FF & ~9'h080, 1'b1, -1);
    // R9: NACK overruled in master receive
    run_byte(2'b10, 8'h00, 9'h0B5, 1'b1, -1);
    // R11: clear in the same slot as a loss keeps the flag
    run_byte(2'b10, 8'h00, 9'h0FF, 1'b1, 8);
    // R11: clear without loss
    run_byte(2'b10, 8'h00, 9'h1FF, 1'b0, 2);
    // R8 R10: slave NACK meets a 0, master receive ACK
    run_byte(2'b00, 8'h00, 9'h05A, 1'b1, -1);
    run_byte(2'b10, 8'h00, 9'h0C3, 1'b0, -1);
    for (int n = 0; n < 40; n++) begin
      logic [8:0] oth;
      int cs;
      oth = 9'h1FF;
      if ($urandom % 4 == 0) oth = 9'($urandom);
      else if ($urandom % 2 == 0) oth[$urandom % 9] = 1'b0;
      cs = ($urandom % 6 == 0) ? int'($urandom % 9) : -1;
      run_byte(2'($urandom % 3), 8'($urandom), oth, 1'($urandom), cs);
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule